// File: doc/BRIEF.md
# Pin Interrupt Controller

This block watches a small set of synchronized input pins and turns each one into an interrupt request toward a parent interrupt controller. Every channel can detect rising edges, falling edges, either edge, a high level or a low level. Software programs it through a plain 32-bit register bus: a byte address, a write enable, write data and combinational read data.

Channel enables are never written directly. Each of the two enable vectors has a write-one-to-set register and a write-one-to-clear register, so software can change one channel without a read-modify-write. Edge events are held in sticky status bits until software clears them. In level mode the second enable vector doubles as the polarity select, and the status follows the qualified pin level. The interrupt outputs form one contiguous vector, channel n on bit n, so that they can feed consecutive parent lines.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 (all channels in edge mode, all enables off, no latched events) and `irq_out` is 0.
- R2: Byte offsets: 0x00 mode, 0x04 pending status, 0x08 rising-edge seen, 0x0C falling-edge seen, 0x10 enable-A state, 0x14 enable-B state, 0x18 enable-A set, 0x1C enable-A clear, 0x20 enable-B set, 0x24 enable-B clear; bit n belongs to channel n. A 1 written to a set (clear) register turns that channel's enable on (off); 0 bits have no effect. The two enable state registers ignore writes, and the set and clear offsets read as 0.
- R3: A pin change sampled at clock edge k appears on `irq_out` after edge k+2 in edge mode and after edge k+1 in level mode.
- R4: With mode bit n at 0 (edge mode), enable-A arms rising-edge detection and enable-B arms falling-edge detection, independently or together; an armed edge sets the pending bit, and `irq_out[n]` is the pending bit while either enable of that channel is on.
- R5: With mode bit n at 1 (level mode), enable-A gates the channel and enable-B selects the active level (1 high, 0 low); the pending bit and `irq_out[n]` equal the gated, level-matched pin and a write to the pending register does not change them.
- R6: The rising-edge-seen and falling-edge-seen registers record every synchronized edge in either mode, whatever the enables, and a 1 written to a bit clears it.
- R7: In edge mode a 1 written to a pending bit clears it and drops `irq_out` for that channel.
- R8: When an armed edge and a pending clear for the same channel land on the same clock edge, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (6) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_CH (8) | Asynchronous input pins, one per channel |
| irq_out | output | NUM_CH (8) | Interrupt requests, channel n on bit n |

## Verification
The function pair that can coincide is detection of an armed edge and a software clear of the same pending bit. The bench times a pin rise so that the synchronized edge reaches the pending register on the same clock edge as a write of 1 to the pending register, after first leaving the bit already set from an earlier edge so that only the priority decides the result. The pending bit must read 1 afterwards, and a later clear with a quiet pin must read 0.

// File: rtl/pic_pkg.sv
package pic_pkg;
   // Register byte offsets
   localparam int unsigned OFF_MODE     = 'h00;
   localparam int unsigned OFF_PEND     = 'h04;
   localparam int unsigned OFF_RISE     = 'h08;
   localparam int unsigned OFF_FALL     = 'h0C;
   localparam int unsigned OFF_ENA      = 'h10;
   localparam int unsigned OFF_ENB      = 'h14;
   localparam int unsigned OFF_ENA_SET  = 'h18;
   localparam int unsigned OFF_ENA_CLR  = 'h1C;
   localparam int unsigned OFF_ENB_SET  = 'h20;
   localparam int unsigned OFF_ENB_CLR  = 'h24;
   localparam int unsigned OFF_LAST     = OFF_ENB_CLR;

   // Detection kind selected by a mode bit
   typedef enum logic {DET_EDGE = 1'b0, DET_LEVEL = 1'b1} det_kind_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pic_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pic_channel.sv
module pic_channel
   import pic_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic mode,
   input  logic en_a,
   input  logic en_b,
   input  logic clr_pend,
   input  logic clr_rise,
   input  logic clr_fall,
   output logic rise_evt,
   output logic fall_evt,
   output logic pend_raw,
   output logic pend_vis,
   output logic rise_seen,
   output logic fall_seen,
   output logic irq
);
   logic prev_q;
   logic hit;
   logic level_ok;
   det_kind_e kind;

   assign kind     = det_kind_e'(mode);
   assign rise_evt = pin_s & ~prev_q;
   assign fall_evt = ~pin_s & prev_q;
   assign hit      = (rise_evt & en_a) | (fall_evt & en_b);
   assign level_ok = en_a & (pin_s == en_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= 1'b0;
         rise_seen <= 1'b0;
         fall_seen <= 1'b0;
         pend_raw  <= 1'b0;
      end else begin
         prev_q    <= pin_s;
         rise_seen <= rise_evt | (rise_seen & ~clr_rise);
         fall_seen <= fall_evt | (fall_seen & ~clr_fall);
         if (kind == DET_LEVEL) pend_raw <= 1'b0;
         else                   pend_raw <= hit | (pend_raw & ~clr_pend);
      end
   end

   always_comb begin
      if (kind == DET_LEVEL) begin
         pend_vis = level_ok;
         irq      = level_ok;
      end else begin
         pend_vis = pend_raw;
         irq      = pend_raw & (en_a | en_b);
      end
   end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
   import pic_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NUM_CH-1:0] pend,
   input  logic [NUM_CH-1:0] rise_seen,
   input  logic [NUM_CH-1:0] fall_seen,
   output logic [NUM_CH-1:0] mode,
   output logic [NUM_CH-1:0] en_a,
   output logic [NUM_CH-1:0] en_b,
   output logic [NUM_CH-1:0] clr_pend,
   output logic [NUM_CH-1:0] clr_rise,
   output logic [NUM_CH-1:0] clr_fall
);
   logic [NUM_CH-1:0] wbits;
   assign wbits = wdata[NUM_CH-1:0];

   if (NUM_CH < DATA_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:NUM_CH];
   end

   function automatic logic hit_at(input logic [ADDR_W-1:0] a, input int unsigned off);
      return a == ADDR_W'(off);
   endfunction

   assign clr_pend = (we && hit_at(addr, OFF_PEND)) ? wbits : '0;
   assign clr_rise = (we && hit_at(addr, OFF_RISE)) ? wbits : '0;
   assign clr_fall = (we && hit_at(addr, OFF_FALL)) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
         en_a <= '0;
         en_b <= '0;
      end else if (we) begin
         if (hit_at(addr, OFF_MODE))    mode <= wbits;
         if (hit_at(addr, OFF_ENA_SET)) en_a <= en_a | wbits;
         if (hit_at(addr, OFF_ENA_CLR)) en_a <= en_a & ~wbits;
         if (hit_at(addr, OFF_ENB_SET)) en_b <= en_b | wbits;
         if (hit_at(addr, OFF_ENB_CLR)) en_b <= en_b & ~wbits;
      end
   end

   always_comb begin
      rdata = '0;
      if      (hit_at(addr, OFF_MODE)) rdata[NUM_CH-1:0] = mode;
      else if (hit_at(addr, OFF_PEND)) rdata[NUM_CH-1:0] = pend;
      else if (hit_at(addr, OFF_RISE)) rdata[NUM_CH-1:0] = rise_seen;
      else if (hit_at(addr, OFF_FALL)) rdata[NUM_CH-1:0] = fall_seen;
      else if (hit_at(addr, OFF_ENA))  rdata[NUM_CH-1:0] = en_a;
      else if (hit_at(addr, OFF_ENB))  rdata[NUM_CH-1:0] = en_b;
   end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
   import pic_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] pin_in,
   output logic [NUM_CH-1:0] irq_out
);
   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("pin_irq_ctrl: NUM_CH must be 1..DATA_W");
   end
   if ((1 << ADDR_W) <= OFF_LAST) begin : g_bad_addr
      $error("pin_irq_ctrl: ADDR_W too narrow for the register map");
   end

   logic [NUM_CH-1:0] pin_s;
   logic [NUM_CH-1:0] mode, en_a, en_b;
   logic [NUM_CH-1:0] clr_pend, clr_rise, clr_fall;
   logic [NUM_CH-1:0] rise_evt, fall_evt;
   logic [NUM_CH-1:0] pend_raw, pend_vis, rise_seen, fall_seen;

   pic_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   pic_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .rdata(bus_rdata),
      .pend(pend_vis), .rise_seen(rise_seen), .fall_seen(fall_seen),
      .mode(mode), .en_a(en_a), .en_b(en_b),
      .clr_pend(clr_pend), .clr_rise(clr_rise), .clr_fall(clr_fall)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pic_channel u_ch (
         .clk(clk), .rst_n(rst_n),
         .pin_s(pin_s[i]), .mode(mode[i]), .en_a(en_a[i]), .en_b(en_b[i]),
         .clr_pend(clr_pend[i]), .clr_rise(clr_rise[i]), .clr_fall(clr_fall[i]),
         .rise_evt(rise_evt[i]), .fall_evt(fall_evt[i]),
         .pend_raw(pend_raw[i]), .pend_vis(pend_vis[i]),
         .rise_seen(rise_seen[i]), .fall_seen(fall_seen[i]),
         .irq(irq_out[i])
      );
   end
endmodule

// File: rtl/pic_checker.sv
module pic_checker
   import pic_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              we,
   input logic [NUM_CH-1:0] wbits,
   input logic [NUM_CH-1:0] mode,
   input logic [NUM_CH-1:0] en_a,
   input logic [NUM_CH-1:0] en_b,
   input logic [NUM_CH-1:0] rise_evt,
   input logic [NUM_CH-1:0] fall_evt,
   input logic [NUM_CH-1:0] rise_seen,
   input logic [NUM_CH-1:0] pend_raw,
   input logic [NUM_CH-1:0] irq_out
);
   // R1: first cycle out of reset has no request
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> irq_out == '0);

   // R2: set strobe turns on every written bit
   p_ena_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(OFF_ENA_SET)) |=> ((en_a & $past(wbits)) == $past(wbits)));

   // R2: clear strobe turns off every written bit
   p_enb_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(OFF_ENB_CLR)) |=> ((en_b & $past(wbits)) == '0));

   // R2: state register ignores writes
   p_ena_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(OFF_ENA)) |=> $stable(en_a));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      // R6: every synchronized rise is recorded
      p_rise_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
         rise_evt[n] |=> rise_seen[n]);

      // R8: armed edge wins over a same-cycle clear
      p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode[n] && rise_evt[n] && en_a[n]) |=> pend_raw[n]);

      // R7: clear with no armed edge empties the pending bit
      p_pend_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr == ADDR_W'(OFF_PEND) && wbits[n] && !mode[n]
          && !(rise_evt[n] && en_a[n]) && !(fall_evt[n] && en_b[n])) |=> !pend_raw[n]);

      // R4: edge channel with both enables off never requests
      p_edge_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode[n] && !en_a[n] && !en_b[n]) |-> !irq_out[n]);
   end
endmodule

bind pin_irq_ctrl pic_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
   .wbits(bus_wdata[NUM_CH-1:0]), .mode(mode), .en_a(en_a), .en_b(en_b),
   .rise_evt(rise_evt), .fall_evt(fall_evt), .rise_seen(rise_seen),
   .pend_raw(pend_raw), .irq_out(irq_out)
);

// File: tb/pin_irq_ctrl_tb_top.sv
module pin_irq_ctrl_tb_top;
   localparam logic [5:0] A_MODE = 6'h00, A_PEND = 6'h04, A_RISE = 6'h08, A_FALL = 6'h0C,
                          A_ENA = 6'h10, A_ENB = 6'h14, A_ENA_SET = 6'h18, A_ENA_CLR = 6'h1C,
                          A_ENB_SET = 6'h20, A_ENB_CLR = 6'h24;

   // {mode, en_a set, en_b set, pins before, pins after, expected irq/pending}
   localparam int NV = 8;
   localparam logic [47:0] VEC [NV] = '{
      {8'h00, 8'hFF, 8'h00, 8'h00, 8'h0F, 8'h0F},   // R4 rising only
      {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h3C, 8'hC3},   // R4 falling only
      {8'h00, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h5A},   // R4 split arming
      {8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00},   // R4 unarmed, R6 still seen
      {8'h00, 8'h81, 8'h81, 8'h01, 8'h80, 8'h81},   // R4 both edges
      {8'hFF, 8'hFF, 8'hF0, 8'h00, 8'h33, 8'h3C},   // R5 mixed polarity
      {8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'h5A, 8'h0A},   // R5 gating
      {8'h0F, 8'hFF, 8'h05, 8'h00, 8'h3C, 8'h36}    // R4/R5 mixed modes
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pin_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq_out(irq_out)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = {24'h0, d};
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clean();
      wr(A_ENA_CLR, 8'hFF); wr(A_ENB_CLR, 8'hFF); wr(A_MODE, 8'h00);
      pin_in = '0; idle(5);
      wr(A_PEND, 8'hFF); wr(A_RISE, 8'hFF); wr(A_FALL, 8'hFF);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      check("R1 irq after reset", {24'h0, irq_out}, 32'h0);
      for (int a = 0; a <= 'h24; a += 4) begin
         rd(6'(a), v);
         check($sformatf("R1 reg %0h after reset", a), v, 32'h0);
      end

      // Vector table walk (R4, R5, R6)
      for (int i = 0; i < NV; i++) begin
         logic [7:0] m, ea, eb, pa, pb, ex;
         {m, ea, eb, pa, pb, ex} = VEC[i];
         clean();
         wr(A_MODE, m); wr(A_ENA_SET, ea); wr(A_ENB_SET, eb);
         pin_in = pa; idle(5);
         wr(A_PEND, 8'hFF); wr(A_RISE, 8'hFF); wr(A_FALL, 8'hFF);
         pin_in = pb; idle(5);
         check($sformatf("R4/R5 vec %0d irq", i), {24'h0, irq_out}, {24'h0, ex});
         rd(A_PEND, v);
         check($sformatf("R4/R5 vec %0d pending", i), v, {24'h0, ex});
         rd(A_RISE, v);
         check($sformatf("R6 vec %0d rise seen", i), v, {24'h0, ~pa & pb});
         rd(A_FALL, v);
         check($sformatf("R6 vec %0d fall seen", i), v, {24'h0, pa & ~pb});
      end

      // R2 set/clear strobes, zero bits, read-only state, strobe reads
      clean();
      wr(A_ENA_SET, 8'h05); rd(A_ENA, v); check("R2 set 05", v, 32'h05);
      wr(A_ENA_SET, 8'h02); rd(A_ENA, v); check("R2 set adds 02", v, 32'h07);
      wr(A_ENA_CLR, 8'h04); rd(A_ENA, v); check("R2 clear 04", v, 32'h03);
      wr(A_ENA_SET, 8'h00); wr(A_ENA_CLR, 8'h00); rd(A_ENA, v);
      check("R2 zero bits no effect", v, 32'h03);
      wr(A_ENA, 8'hFF); rd(A_ENA, v); check("R2 state ignores write", v, 32'h03);
      wr(A_ENB_SET, 8'hA0); wr(A_ENB_CLR, 8'h20); rd(A_ENB, v);
      check("R2 enable-B set/clear", v, 32'h80);
      rd(A_ENA_SET, v); check("R2 set offset reads 0", v, 32'h0);

      // R3 latency, edge mode
      clean();
      wr(A_ENA_SET, 8'h04);
      @(negedge clk); pin_in[2] = 1'b1;
      @(negedge clk); check("R3 edge after k", {31'h0, irq_out[2]}, 32'h0);
      @(negedge clk); check("R3 edge after k+1", {31'h0, irq_out[2]}, 32'h0);
      @(negedge clk); check("R3 edge after k+2", {31'h0, irq_out[2]}, 32'h1);

      // R3 latency, level mode active-high
      clean();
      wr(A_MODE, 8'h08); wr(A_ENA_SET, 8'h08); wr(A_ENB_SET, 8'h08);
      @(negedge clk); pin_in[3] = 1'b1;
      @(negedge clk); check("R3 level after k", {31'h0, irq_out[3]}, 32'h0);
      @(negedge clk); check("R3 level after k+1", {31'h0, irq_out[3]}, 32'h1);
      // R5 pending write ignored in level mode
      wr(A_PEND, 8'hFF); idle(1);
      rd(A_PEND, v); check("R5 level pending not cleared", v, 32'h08);
      check("R5 level irq held", {24'h0, irq_out}, 32'h08);

      // R7 clear and mask behaviour in edge mode
      clean();
      wr(A_ENA_SET, 8'h02);
      pin_in[1] = 1'b1; idle(5);
      check("R7 irq before clear", {24'h0, irq_out}, 32'h02);
      wr(A_ENA_CLR, 8'h02); idle(1);
      check("R4 disabled channel masked", {24'h0, irq_out}, 32'h0);
      rd(A_PEND, v); check("R4 pending kept while masked", v, 32'h02);
      wr(A_PEND, 8'h02); rd(A_PEND, v); check("R7 pending cleared", v, 32'h0);

      // R8 edge and clear on the same clock edge
      clean();
      wr(A_ENA_SET, 8'h01);
      pin_in[0] = 1'b1; idle(5);
      pin_in[0] = 1'b0; idle(5);
      rd(A_PEND, v); check("R8 pending set before collision", v, 32'h01);
      @(negedge clk); pin_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk); bus_addr = A_PEND; bus_we = 1'b1; bus_wdata = 32'h01;
      @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
      rd(A_PEND, v); check("R8 edge wins over clear", v, 32'h01);
      idle(3);
      wr(A_PEND, 8'h01); rd(A_PEND, v); check("R8 quiet clear empties", v, 32'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule